// File: doc/BRIEF.md
# Flash Erase-Verify Command Controller

This block drives the erase-verify operation of a small non-volatile array. The array is modelled here as a register array. Software reaches the block through a byte-wide register bus. Before any command it must load a clock divider value. It then launches a verify with three writes in a fixed order:

- any data to an address inside the array;
- the verify opcode to the command register;
- a launch value to the status register.

The controller checks that this order is kept, holds one launched command in a single-entry buffer, and reads every array word in turn. At the end it reports through a blank flag whether all words hold the erased value (all ones).

A wrong step raises a sticky error flag and throws the partial sequence away. While that flag is up, sequence writes are ignored; software clears it by writing a one to its bit. A second command may be launched while the first is still running. When the first finishes, the second starts at once and the completion flag stays low until the second is done.

A side port lets a test environment preload array contents. Bus writes never change the array.

Top module: `fev_ctrl`

## Requirements
- R1: After reset the status register (bus address 0x11) reads 0xC0 and the divider register (address 0x10) reads 0x00. The status bits are: bit 7 buffer-free, bit 6 done, bit 4 error, bit 2 blank; all other status bits read 0.
- R2: A write to the divider register stores its low 7 bits and sets bit 7 (divider loaded), and bit 7 stays set. An array write made while bit 7 is clear sets the error bit.
- R3: Each of the following sets the error bit (status bit 4) and discards the sequence:
  - a command write that does not directly follow an array write;
  - a status write with bit 7 set that does not directly follow a command write;
  - an array write during an open sequence, or while the buffer is full;
  - any opcode other than 0x05.
  While the error bit is set, all sequence writes are ignored. A status write with bit 4 set only clears the error bit.
- R4: The launch sequence is an array write, then opcode 0x05 to the command register (address 0x12), then 0x80 to the status register. Done and buffer-free read 0 after the launch edge. When the engine is idle, buffer-free returns to 1 one cycle later.
- R5: With the engine idle, done sets exactly DEPTH+12 clock cycles after the launch edge.
- R6: Blank clears when a verify starts. At completion it is set only if every array word equals 0xFF.
- R7: Writing 0x00 to the status register during an open sequence aborts it without an error and without a launch. A later 0x80 write then counts as out of order.
- R8: A command launched while another is running waits in the buffer. At the first completion it starts, done stays 0 and buffer-free returns to 1. It completes DEPTH+11 cycles after that first completion.
- R9: Bus addresses with the top bit clear read the array word at that index. Bus writes, including the sequence's dummy write, leave the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Bus write strobe, one write per cycle |
| bus_addr | input | AW | Top bit 1 selects registers (offset 0 divider, 1 status, 2 command); top bit 0 selects array word |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| ld_en | input | 1 | Preload strobe for the array |
| ld_addr | input | IW | Preload word index |
| ld_data | input | 8 | Preload word |

## Verification
Every bus write takes effect at the rising edge on which it is presented. Status is therefore sampled at the next falling edge for the launch and error effects. Buffer release is due one falling edge later. Completion is due DEPTH+12 falling edges after a launch on an idle engine, and 2·DEPTH+23 after the first of two back-to-back launches spaced four cycles apart. The bench counts falling edges from the launch write and compares the count with these sums, which it computes from DEPTH. Blank results are swept over every single-word fault position and compared with the result of an all-ones test run over the preloaded image.

// File: rtl/fev_pkg.sv
package fev_pkg;
  localparam int BUS_W = 8;
  localparam logic [BUS_W-1:0] OPC_VERIFY = 8'h05;
  localparam int ST_FREE  = 7;
  localparam int ST_DONE  = 6;
  localparam int ST_ERR   = 4;
  localparam int ST_BLANK = 2;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ADDR, SEQ_CMD} seq_state_t;

  // total cycles from launch edge to completion edge on an idle engine
  function automatic int verify_cycles(int depth);
    return depth + 12;
  endfunction

  function automatic logic [BUS_W-1:0] pack_status(logic free, logic done,
                                                   logic err, logic blank);
    logic [BUS_W-1:0] s;
    s = '0;
    s[ST_FREE]  = free;
    s[ST_DONE]  = done;
    s[ST_ERR]   = err;
    s[ST_BLANK] = blank;
    return s;
  endfunction
endpackage

// File: rtl/fev_array.sv
module fev_array #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     ld_en,
  input  logic [IW-1:0]            ld_addr,
  input  logic [fev_pkg::BUS_W-1:0] ld_data,
  input  logic [IW-1:0]            rd_addr,
  output logic [fev_pkg::BUS_W-1:0] rd_data,
  input  logic [IW-1:0]            scan_addr,
  output logic [fev_pkg::BUS_W-1:0] scan_data
);
  logic [fev_pkg::BUS_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
  end

  assign rd_data   = mem[rd_addr];
  assign scan_data = mem[scan_addr];
endmodule

// File: rtl/fev_seq.sv
module fev_seq
  import fev_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_arr,
  input  logic             wr_stat,
  input  logic             wr_cmd,
  input  logic [BUS_W-1:0] wdata,
  input  logic             div_loaded,
  input  logic             buf_free,
  output logic             launch,
  output logic             err_set,
  output logic             acc_err
);
  seq_state_t state, state_nxt;
  logic       err_clr;

  always_comb begin
    state_nxt = state;
    launch    = 1'b0;
    err_set   = 1'b0;
    err_clr   = 1'b0;
    if (wr_stat && wdata[ST_ERR]) begin
      err_clr = 1'b1;
    end else if (!acc_err) begin
      if (wr_arr) begin
        if (state == SEQ_IDLE && div_loaded && buf_free) state_nxt = SEQ_ADDR;
        else err_set = 1'b1;
      end else if (wr_cmd) begin
        if (state == SEQ_ADDR && wdata == OPC_VERIFY) state_nxt = SEQ_CMD;
        else err_set = 1'b1;
      end else if (wr_stat) begin
        if (wdata == '0) begin
          state_nxt = SEQ_IDLE;
        end else if (wdata[ST_FREE]) begin
          if (state == SEQ_CMD) begin
            launch    = 1'b1;
            state_nxt = SEQ_IDLE;
          end else begin
            err_set = 1'b1;
          end
        end
      end
      if (err_set) state_nxt = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      acc_err <= 1'b0;
    end else begin
      state <= state_nxt;
      if (err_clr)      acc_err <= 1'b0;
      else if (err_set) acc_err <= 1'b1;
    end
  end
endmodule

// File: rtl/fev_engine.sv
module fev_engine
  import fev_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(verify_cycles(DEPTH)) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [BUS_W-1:0] scan_data,
  output logic [IW-1:0]    scan_addr,
  output logic             buf_free,
  output logic             done,
  output logic             blank,
  output logic             busy,
  output logic             start,
  output logic             finish
);
  localparam logic [CW-1:0] LAST_C  = CW'(verify_cycles(DEPTH) - 2);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic          pending;
  logic [CW-1:0] cnt;
  logic          all_ones;

  assign buf_free  = !pending;
  assign finish    = busy && (cnt == LAST_C);
  assign start     = pending && (!busy || finish);
  assign scan_addr = cnt[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      all_ones <= 1'b0;
      blank    <= 1'b0;
      done     <= 1'b1;
    end else begin
      if (launch)     pending <= 1'b1;
      else if (start) pending <= 1'b0;

      if (start) begin
        busy     <= 1'b1;
        cnt      <= '0;
        all_ones <= 1'b1;
        blank    <= 1'b0;
      end else if (finish) begin
        busy  <= 1'b0;
        blank <= all_ones;
        done  <= 1'b1;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt < DEPTH_C) all_ones <= all_ones & (scan_data == '1);
      end

      if (launch) done <= 1'b0;
    end
  end
endmodule

// File: rtl/fev_ctrl.sv
module fev_ctrl
  import fev_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int AW = IW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             ld_en,
  input  logic [IW-1:0]    ld_addr,
  input  logic [BUS_W-1:0] ld_data
);
  logic       is_reg;
  logic [1:0] reg_off;
  logic       wr_arr, wr_div, wr_stat, wr_cmd;

  logic [BUS_W-2:0] div_val;
  logic             div_loaded;

  logic             launch_pulse, err_pulse, acc_err;
  logic             start_pulse, finish_pulse, busy;
  logic             buf_free, done_flag, blank_flag;
  logic [IW-1:0]    scan_addr;
  logic [BUS_W-1:0] scan_data, arr_rdata;

  assign is_reg  = bus_addr[AW-1];
  assign reg_off = bus_addr[1:0];
  assign wr_arr  = bus_we && !is_reg;
  assign wr_div  = bus_we && is_reg && reg_off == 2'd0;
  assign wr_stat = bus_we && is_reg && reg_off == 2'd1;
  assign wr_cmd  = bus_we && is_reg && reg_off == 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_val    <= '0;
      div_loaded <= 1'b0;
    end else if (wr_div) begin
      div_val    <= bus_wdata[BUS_W-2:0];
      div_loaded <= 1'b1;
    end
  end

  fev_array #(.DEPTH(DEPTH)) u_array (
    .clk(clk), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(bus_addr[IW-1:0]), .rd_data(arr_rdata),
    .scan_addr(scan_addr), .scan_data(scan_data)
  );

  fev_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_arr(wr_arr), .wr_stat(wr_stat),
    .wr_cmd(wr_cmd), .wdata(bus_wdata), .div_loaded(div_loaded),
    .buf_free(buf_free), .launch(launch_pulse), .err_set(err_pulse),
    .acc_err(acc_err)
  );

  fev_engine #(.DEPTH(DEPTH)) u_engine (
    .clk(clk), .rst_n(rst_n), .launch(launch_pulse), .scan_data(scan_data),
    .scan_addr(scan_addr), .buf_free(buf_free), .done(done_flag),
    .blank(blank_flag), .busy(busy), .start(start_pulse),
    .finish(finish_pulse)
  );

  always_comb begin
    if (!is_reg) begin
      bus_rdata = arr_rdata;
    end else begin
      unique case (reg_off)
        2'd0:    bus_rdata = {div_loaded, div_val};
        2'd1:    bus_rdata = pack_status(buf_free, done_flag, acc_err, blank_flag);
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fev_ctrl_chk.sv
module fev_ctrl_chk #(
  parameter int DEPTH = 16
) (
  input logic clk,
  input logic rst_n,
  input logic launch,
  input logic err_set,
  input logic start,
  input logic finish,
  input logic busy,
  input logic buf_free,
  input logic done,
  input logic blank,
  input logic acc_err,
  input logic div_loaded
);
  int chk_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              chk_cnt <= 0;
    else if (start)          chk_cnt <= 0;
    else if (chk_cnt < 4096) chk_cnt <= chk_cnt + 1;
  end

  a_r4_free_drops: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !buf_free);
  a_r4_idle_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy) |=> (start && !done));
  a_r5_span: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (chk_cnt == DEPTH + 10));
  a_r8_queued_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !buf_free) |=> (!done && busy && buf_free));
  a_r3_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> !launch);
  a_r3_err_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> acc_err);
  a_r2_div_needed: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> div_loaded);
  a_r6_blank_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !blank);
endmodule

bind fev_ctrl fev_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch_pulse), .err_set(err_pulse),
  .start(start_pulse), .finish(finish_pulse), .busy(busy),
  .buf_free(buf_free), .done(done_flag), .blank(blank_flag),
  .acc_err(acc_err), .div_loaded(div_loaded)
);

// File: tb/fev_ctrl_bench.sv
module fev_ctrl_bench;
  localparam int N  = 16;
  localparam int IW = $clog2(N);
  localparam int AW = IW + 1;
  localparam logic [AW-1:0] A_DIV  = AW'(N);
  localparam logic [AW-1:0] A_STAT = AW'(N + 1);
  localparam logic [AW-1:0] A_CMD  = AW'(N + 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          ld_en = 1'b0;
  logic [IW-1:0] ld_addr = '0;
  logic [7:0]    ld_data = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fev_ctrl #(.DEPTH(N)) u_fev_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ld_en(ld_en),
    .ld_addr(ld_addr), .ld_data(ld_data)
  );

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic preload(int i, logic [7:0] d);
    ld_en = 1'b1; ld_addr = IW'(i); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic launch3();
    wr(AW'(3), 8'hA5);
    wr(A_CMD, 8'h05);
    wr(A_STAT, 8'h80);
  endtask

  // counts falling edges after the launch write until done is seen
  task automatic wait_done(inout int k);
    logic [7:0] s;
    rd(A_STAT, s);
    while (!s[6] && k < 2000) begin
      @(negedge clk);
      k++;
      rd(A_STAT, s);
    end
  endtask

  function automatic int stat(bit free, bit done, bit err, bit blank);
    return (int'(free) << 7) | (int'(done) << 6) | (int'(err) << 4) | (int'(blank) << 2);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] s;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(A_STAT, s); check("R1 status", s, stat(1, 1, 0, 0));
    rd(A_DIV, s);  check("R1 divider", s, 8'h00);

    wr(AW'(3), 8'hAA);
    rd(A_STAT, s); check("R2 no divider", s, stat(1, 1, 1, 0));
    wr(A_STAT, 8'h10);
    rd(A_STAT, s); check("R3 clear", s, stat(1, 1, 0, 0));
    wr(A_DIV, 8'h05);
    rd(A_DIV, s);  check("R2 divider", s, 8'h85);

    for (int i = 0; i < N; i++) preload(i, 8'hFF);
    preload(5, 8'h3C);
    rd(AW'(5), s); check("R9 array read", s, 8'h3C);
    preload(5, 8'hFF);

    // idle engine launch timing
    launch3();
    k = 0;
    rd(A_STAT, s); check("R4 after launch", s, stat(0, 0, 0, 0));
    @(negedge clk); k++;
    rd(A_STAT, s); check("R4 buffer released", s, stat(1, 0, 0, 0));
    wait_done(k);
    check("R5 cycles", k, N + 12);
    rd(A_STAT, s); check("R6 blank erased", s, stat(1, 1, 0, 1));
    rd(AW'(3), s); check("R9 dummy write", s, 8'hFF);

    // single faulty word at every position
    for (int p = 0; p < N; p++) begin
      preload(p, 8'hFE ^ 8'(p << 4));
      launch3();
      k = 0;
      @(negedge clk); k++;
      rd(A_STAT, s); check("R6 blank cleared at start", s, stat(1, 0, 0, 0));
      wait_done(k);
      check("R5 cycles sweep", k, N + 12);
      rd(A_STAT, s); check("R6 blank fault", s, stat(1, 1, 0, 0));
      preload(p, 8'hFF);
    end
    launch3();
    k = 0;
    wait_done(k);
    rd(A_STAT, s); check("R6 blank restored", s, stat(1, 1, 0, 1));

    // out-of-order steps
    wr(A_CMD, 8'h05);
    rd(A_STAT, s); check("R3 cmd first", s, stat(1, 1, 1, 1));
    launch3();
    repeat (3) @(negedge clk);
    rd(A_STAT, s); check("R3 ignored while error", s, stat(1, 1, 1, 1));
    wr(A_STAT, 8'h10);
    wr(A_STAT, 8'h80);
    rd(A_STAT, s); check("R3 launch first", s, stat(1, 1, 1, 1));
    wr(A_STAT, 8'h10);
    wr(AW'(1), 8'h00);
    wr(A_CMD, 8'h02);
    rd(A_STAT, s); check("R3 bad opcode", s, stat(1, 1, 1, 1));
    wr(A_STAT, 8'h10);
    wr(AW'(1), 8'h00);
    wr(AW'(2), 8'h00);
    rd(A_STAT, s); check("R3 double array write", s, stat(1, 1, 1, 1));
    wr(A_STAT, 8'h10);

    // abort
    wr(AW'(1), 8'h00);
    wr(A_CMD, 8'h05);
    wr(A_STAT, 8'h00);
    repeat (2) @(negedge clk);
    rd(A_STAT, s); check("R7 abort", s, stat(1, 1, 0, 1));
    wr(A_STAT, 8'h80);
    rd(A_STAT, s); check("R7 sequence discarded", s, stat(1, 1, 1, 1));
    wr(A_STAT, 8'h10);

    // queued second command
    launch3();
    k = 0;
    @(negedge clk); k++;
    launch3(); k += 3;
    rd(A_STAT, s); check("R8 buffer full", s, stat(0, 0, 0, 0));
    wr(AW'(2), 8'h00); k++;
    rd(A_STAT, s); check("R3 write while full", s, stat(0, 0, 1, 0));
    wr(A_STAT, 8'h10); k++;
    while (k < N + 12) begin @(negedge clk); k++; end
    rd(A_STAT, s); check("R8 first done held low", s, stat(1, 0, 0, 0));
    wait_done(k);
    check("R8 cycles", k, 2 * N + 23);
    rd(A_STAT, s); check("R8 final", s, stat(1, 1, 0, 1));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule